// File: doc/BRIEF.md
# Bit-Granular Address Stepper

This block moves a bit-precise virtual address forward or backward by a signed distance given in bits. The address has three fields. A 4-bit field selects a bit inside a word. A 16-bit field holds the page and word. An 8-bit segment byte sits above both. The distance is split into two parts. Its low nibble is added to the bit field. The remaining bits, shifted down by four, are added to the word field. The nibble carry supplies one extra word.

A caller pulses `start_i` while the block is idle, with the current address fields and the increment on the inputs. The block then runs a short sequence of steps. A negative increment takes one extra step to sign-fill the word part. An update of the segment byte also takes its own step. At the end, `done_o` pulses for one cycle. From that cycle on, the updated fields and the segment adjust flags stay on the outputs until the next accepted start.

Top module: `bit_addr_stepper`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `seg_inc_o` and `seg_dec_o` are all low.
- R2: The resulting bit field is the low 4 bits of `bit_i + inc_i[3:0]`. A carry out of that 4-bit add is the nibble carry.
- R3: The resulting word field is `word_i` plus the increment shifted arithmetically right by 4, plus the nibble carry, modulo 2^16.
- R4: For a non-negative increment (`inc_i[15]` = 0), a carry out of the 16-bit word add raises `seg_inc_o` and the segment byte becomes `seg_i + 1`. Without that carry, the segment byte stays unchanged and both flags stay low.
- R5: For a negative increment (`inc_i[15]` = 1), the absence of a carry out of the word add raises `seg_dec_o` and the segment byte becomes `seg_i - 1`. With a carry, the segment byte stays unchanged. The two flags are never high together.
- R6: `done_o` goes high exactly 2 cycles after the accepting clock edge. This grows by 1 for a negative increment and by 1 more when the segment byte changes.
- R7: `done_o` is high for exactly one cycle. `busy_o` is high from the accepting edge until `done_o` rises, and it is low while `done_o` is high. `neg_o` gives the sign of the accepted increment.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The result is that of the operation already running.
- R9: The segment byte wraps modulo 256: 0xFF steps up to 0x00, and 0x00 steps down to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| inc_i | input | 16 | Signed increment in bits |
| bit_i | input | 4 | Current bit-within-word field |
| word_i | input | 16 | Current page-and-word field |
| seg_i | input | 8 | Current segment byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| neg_o | output | 1 | Accepted increment was negative |
| bit_o | output | 4 | Updated bit field |
| word_o | output | 16 | Updated page-and-word field |
| seg_o | output | 8 | Updated segment byte |
| seg_inc_o | output | 1 | Segment byte was incremented |
| seg_dec_o | output | 1 | Segment byte was decremented |

## Verification
The result is due 2, 3 or 4 cycles after the accepting edge, depending on the sign of the increment and on whether the segment byte moves. The bench works out that count for each case from the requirements. After the start is accepted, it counts clock edges and samples on each falling edge. It flags a `done_o` that arrives on the wrong count, and then compares the fields in that same cycle against a 28-bit sum of the old address and the sign-extended increment. One more falling edge confirms that `done_o` has dropped. In a separate run, a second start is poked in on the first busy cycle, and the bench checks that the result still matches the first operation.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BIT  = 3'd1,
        ST_SIGN = 3'd2,
        ST_WORD = 3'd3,
        ST_SEG  = 3'd4
    } stp_state_e;

    typedef struct packed {
        logic neg;
        logic nib_carry;
        logic seg_up;
        logic seg_down;
    } stp_flags_t;

endpackage

// File: rtl/stp_bit_add.sv
module stp_bit_add #(
    parameter int BIT_W = 4
) (
    input  logic [BIT_W-1:0] bit_in,
    input  logic [BIT_W-1:0] inc_lo,
    output logic [BIT_W-1:0] bit_sum,
    output logic             nib_carry
);
    logic [BIT_W:0] wide;

    always_comb begin
        wide      = {1'b0, bit_in} + {1'b0, inc_lo};
        bit_sum   = wide[BIT_W-1:0];
        nib_carry = wide[BIT_W];
    end
endmodule

// File: rtl/stp_step_shape.sv
module stp_step_shape #(
    parameter int BIT_W  = 4,
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] inc_in,
    input  logic [WORD_W-1:0] step_in,
    output logic [WORD_W-1:0] step_raw,
    output logic [WORD_W-1:0] step_filled
);
    localparam logic [WORD_W-1:0] LO_MASK = WORD_W'((1 << BIT_W) - 1);
    localparam logic [WORD_W-1:0] HI_FILL = LO_MASK << (WORD_W - BIT_W);

    logic [WORD_W-1:0] cleared;

    always_comb begin
        cleared     = inc_in & ~LO_MASK;
        step_raw    = {cleared[BIT_W-1:0], cleared[WORD_W-1:BIT_W]};
        step_filled = step_in | HI_FILL;
    end
endmodule

// File: rtl/stp_word_add.sv
module stp_word_add #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] step_in,
    input  logic              carry_in,
    input  logic              neg,
    output logic [WORD_W-1:0] word_sum,
    output logic              seg_up,
    output logic              seg_down
);
    logic [WORD_W:0] wide;

    always_comb begin
        wide     = {1'b0, word_in} + {1'b0, step_in} + {{WORD_W{1'b0}}, carry_in};
        word_sum = wide[WORD_W-1:0];
        seg_up   = !neg && wide[WORD_W];
        seg_down = neg && !wide[WORD_W];
    end
endmodule

// File: rtl/stp_seg_adj.sv
module stp_seg_adj #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] seg_in,
    input  logic             down,
    output logic [SEG_W-1:0] seg_out
);
    localparam logic [SEG_W-1:0] ONE = SEG_W'(1);

    always_comb begin
        seg_out = down ? (seg_in - ONE) : (seg_in + ONE);
    end
endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       neg,
    input  logic       need_fix,
    output stp_state_e state,
    output logic       accept,
    output logic       busy,
    output logic       done
);
    stp_state_e nxt;
    logic       done_nxt;

    assign accept = start && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    always_comb begin
        nxt      = state;
        done_nxt = 1'b0;
        case (state)
            ST_IDLE: if (start) nxt = ST_BIT;
            ST_BIT:  nxt = neg ? ST_SIGN : ST_WORD;
            ST_SIGN: nxt = ST_WORD;
            ST_WORD: begin
                if (need_fix) begin
                    nxt = ST_SEG;
                end else begin
                    nxt      = ST_IDLE;
                    done_nxt = 1'b1;
                end
            end
            ST_SEG: begin
                nxt      = ST_IDLE;
                done_nxt = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= done_nxt;
        end
    end
endmodule

// File: rtl/bit_addr_stepper.sv
module bit_addr_stepper
    import stp_pkg::*;
#(
    parameter int BIT_W  = 4,
    parameter int WORD_W = 16,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] inc_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEG_W-1:0]  seg_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              neg_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic [WORD_W-1:0] word_o,
    output logic [SEG_W-1:0]  seg_o,
    output logic              seg_inc_o,
    output logic              seg_dec_o
);
    localparam int SIGN_POS = WORD_W - 1;

    stp_state_e        state;
    logic              accept;
    stp_flags_t        flg_q;
    logic [WORD_W-1:0] inc_q;
    logic [WORD_W-1:0] step_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] word_q;
    logic [SEG_W-1:0]  seg_q;

    logic [BIT_W-1:0]  bit_sum;
    logic              nib_c;
    logic [WORD_W-1:0] step_raw;
    logic [WORD_W-1:0] step_filled;
    logic [WORD_W-1:0] word_sum;
    logic              up_w;
    logic              down_w;
    logic [SEG_W-1:0]  seg_next;

    stp_bit_add #(.BIT_W(BIT_W)) u_bit (
        .bit_in   (bit_q),
        .inc_lo   (inc_q[BIT_W-1:0]),
        .bit_sum  (bit_sum),
        .nib_carry(nib_c)
    );

    stp_step_shape #(.BIT_W(BIT_W), .WORD_W(WORD_W)) u_shape (
        .inc_in     (inc_q),
        .step_in    (step_q),
        .step_raw   (step_raw),
        .step_filled(step_filled)
    );

    stp_word_add #(.WORD_W(WORD_W)) u_word (
        .word_in (word_q),
        .step_in (step_q),
        .carry_in(flg_q.nib_carry),
        .neg     (flg_q.neg),
        .word_sum(word_sum),
        .seg_up  (up_w),
        .seg_down(down_w)
    );

    stp_seg_adj #(.SEG_W(SEG_W)) u_seg (
        .seg_in (seg_q),
        .down   (flg_q.seg_down),
        .seg_out(seg_next)
    );

    stp_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .neg     (flg_q.neg),
        .need_fix(up_w || down_w),
        .state   (state),
        .accept  (accept),
        .busy    (busy_o),
        .done    (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q  <= '0;
            inc_q  <= '0;
            step_q <= '0;
            bit_q  <= '0;
            word_q <= '0;
            seg_q  <= '0;
        end else if (accept) begin
            flg_q.neg       <= inc_i[SIGN_POS];
            flg_q.nib_carry <= 1'b0;
            flg_q.seg_up    <= 1'b0;
            flg_q.seg_down  <= 1'b0;
            inc_q           <= inc_i;
            bit_q           <= bit_i;
            word_q          <= word_i;
            seg_q           <= seg_i;
        end else begin
            case (state)
                ST_BIT: begin
                    bit_q           <= bit_sum;
                    flg_q.nib_carry <= nib_c;
                    step_q          <= step_raw;
                end
                ST_SIGN: step_q <= step_filled;
                ST_WORD: begin
                    word_q         <= word_sum;
                    flg_q.seg_up   <= up_w;
                    flg_q.seg_down <= down_w;
                end
                ST_SEG:  seg_q <= seg_next;
                default: ;
            endcase
        end
    end

    assign neg_o     = flg_q.neg;
    assign bit_o     = bit_q;
    assign word_o    = word_q;
    assign seg_o     = seg_q;
    assign seg_inc_o = flg_q.seg_up;
    assign seg_dec_o = flg_q.seg_down;
endmodule

// File: rtl/stp_chk.sv
module stp_chk #(
    parameter int SEG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             neg_o,
    input logic [SEG_W-1:0] seg_o,
    input logic             seg_inc_o,
    input logic             seg_dec_o
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o)); // R7
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seg_inc_o, seg_dec_o})); // R5
    AST_SEG_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (done_o && seg_inc_o) |-> (seg_o == SEG_W'($past(seg_o) + 1'b1))); // R4
    AST_SEG_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (done_o && seg_dec_o) |-> (seg_o == SEG_W'($past(seg_o) - 1'b1))); // R5
    AST_POS_NO_DEC: assert property (@(posedge clk) disable iff (rst)
        (done_o && !neg_o) |-> !seg_dec_o); // R4
    AST_NEG_NO_INC: assert property (@(posedge clk) disable iff (rst)
        (done_o && neg_o) |-> !seg_inc_o); // R5
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(neg_o)); // R8
endmodule

bind bit_addr_stepper stp_chk #(.SEG_W(SEG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .neg_o    (neg_o),
    .seg_o    (seg_o),
    .seg_inc_o(seg_inc_o),
    .seg_dec_o(seg_dec_o)
);

// File: tb/sim_bit_addr_stepper.sv
module sim_bit_addr_stepper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] inc_i = '0;
    logic [3:0]  bit_i = '0;
    logic [15:0] word_i = '0;
    logic [7:0]  seg_i = '0;
    logic        busy_o, done_o, neg_o, seg_inc_o, seg_dec_o;
    logic [3:0]  bit_o;
    logic [15:0] word_o;
    logic [7:0]  seg_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_addr_stepper u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .inc_i(inc_i),
        .bit_i(bit_i), .word_i(word_i), .seg_i(seg_i),
        .busy_o(busy_o), .done_o(done_o), .neg_o(neg_o),
        .bit_o(bit_o), .word_o(word_o), .seg_o(seg_o),
        .seg_inc_o(seg_inc_o), .seg_dec_o(seg_dec_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] b, input logic [15:0] w, input logic [7:0] s,
                          input logic [15:0] inc, input bit poke);
        logic [27:0] full_exp;
        logic [7:0]  e_seg;
        bit          e_neg, e_up, e_dn;
        int          lat, n;
        full_exp = {s, w, b} + {{12{inc[15]}}, inc};
        e_seg = full_exp[27:20];
        e_neg = inc[15];
        e_up  = !e_neg && (e_seg != s);
        e_dn  = e_neg && (e_seg != s);
        lat   = 2 + (e_neg ? 1 : 0) + ((e_seg != s) ? 1 : 0);
        @(negedge clk);
        start_i = 1'b1; inc_i = inc; bit_i = b; word_i = w; seg_i = s;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            inc_i = ~inc; bit_i = ~b; word_i = ~w; seg_i = ~s;
        end else begin
            start_i = 1'b0;
        end
        check(busy_o == 1'b1, "R7 busy", busy_o, 1);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (done_o) break;
        end
        check(n == lat, "R6 latency", n, lat);
        check(bit_o == full_exp[3:0], "R2 bit", bit_o, full_exp[3:0]);
        check(word_o == full_exp[19:4], poke ? "R8 word" : "R3 word", word_o, full_exp[19:4]);
        check(seg_o == e_seg, e_neg ? "R5 seg" : "R4 seg", seg_o, e_seg);
        check(seg_inc_o == e_up, "R4 seg_inc", seg_inc_o, e_up);
        check(seg_dec_o == e_dn, "R5 seg_dec", seg_dec_o, e_dn);
        check(neg_o == e_neg && busy_o == 1'b0, "R7 neg/busy", {neg_o, busy_o}, {e_neg, 1'b0});
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done width", done_o, 0);
    endtask

    initial begin
        logic [15:0] incs [16];
        logic [15:0] words [4];
        logic [7:0]  segs [3];
        incs = '{16'h0000, 16'h0001, 16'h0005, 16'h000F, 16'h0010, 16'h0011, 16'h7FFF, 16'h0123,
                 16'hFFFF, 16'hFFFB, 16'hFFF0, 16'hFFEF, 16'h8000, 16'hFEDC, 16'h00F0, 16'hFFF0};
        words = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFE};
        segs  = '{8'h00, 8'hFF, 8'h5A};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy_o && !done_o && !seg_inc_o && !seg_dec_o, "R1 reset",
              {busy_o, done_o, seg_inc_o, seg_dec_o}, 0);
        // R9: segment wrap in both directions
        run_op(4'hF, 16'hFFFF, 8'hFF, 16'h0001, 1'b0);
        check(seg_o == 8'h00, "R9 wrap up", seg_o, 8'h00);
        run_op(4'h0, 16'h0000, 8'h00, 16'hFFFF, 1'b0);
        check(seg_o == 8'hFF, "R9 wrap down", seg_o, 8'hFF);
        // R8: start while busy is ignored
        run_op(4'h3, 16'h1234, 8'h10, 16'h0045, 1'b1);
        run_op(4'h8, 16'h0000, 8'h20, 16'hFFE0, 1'b1);
        for (int si = 0; si < 3; si++)
            for (int wi = 0; wi < 4; wi++)
                for (int ii = 0; ii < 16; ii++)
                    for (int b = 0; b < 16; b++)
                        run_op(4'(b), words[wi], segs[si], incs[ii], 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule